// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed operands and either adds the product to a wide accumulator or loads it there. The accumulator has guard bits above the full product width, so long runs of accumulation can proceed before the signed range is exceeded. A fractional mode treats the operands as Q15 values and doubles the product, so that the accumulated result is in Q31 form. The block also offers three accumulator-only operations: clear, a one-place arithmetic left shift and a one-place arithmetic right shift.

A caller places the operands, the operation code and the fractional select on the inputs and raises `start` for one clock. The accumulator and the overflow flag take their new values at that clock edge. `done` is high during the following cycle. Operations may be issued back to back, one per clock. The overflow flag is sticky. When the signed range is exceeded the accumulator wraps and does not saturate.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `acc` is 0, `ovf` is 0 and `done` is 0.
- R2: Operation code 1 (accumulate) with `frac`=0 adds the signed 32-bit product of `a` and `b`, sign-extended to 40 bits, to `acc`, modulo 2^40.
- R3: When `frac`=1, the product used by codes 1 and 2 is first doubled by a shift one place left. For example, -32768 times -32768 gives 0x0080000000.
- R4: Operation code 2 (load) replaces `acc` with the sign-extended product. It does not change `ovf`.
- R5: Operation code 3 (clear) sets `acc` and `ovf` to zero in a single cycle.
- R6: Operation code 4 (shift left) moves `acc` up one bit and puts zero into bit 0. It sets `ovf` when bits 39 and 38 differed before the shift.
- R7: Operation code 5 (shift right) moves `acc` down one bit and keeps bit 39 unchanged.
- R8: An accumulate whose true signed sum lies outside [-2^39, 2^39-1] sets `ovf` and leaves the wrapped sum in `acc`. Once set, `ovf` stays high until a clear or a reset.
- R9: `done` is high exactly in the cycle after a cycle with `start` high. While `start` is low, `acc` and `ovf` hold.
- R10: Operation codes 0, 6 and 7 leave `acc` and `ovf` unchanged, and `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the operation on `op` in this cycle |
| op | input | 3 | Operation code (0 none, 1 accumulate, 2 load, 3 clear, 4 shift left, 5 shift right) |
| frac | input | 1 | Fractional (Q15) product select |
| a | input | 16 | Signed operand A |
| b | input | 16 | Signed operand B |
| acc | output | 40 | Accumulator contents |
| ovf | output | 1 | Sticky signed overflow flag |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default values: 16-bit operands, a 40-bit accumulator and fractional support enabled. With these values the eight guard bits can be driven to overflow within a small number of operations. Eight left shifts of a loaded fractional full-scale product overflow, and so do 128 accumulates of that product onto 2^38. A reference model using 64-bit integers checks the wrap and the flag. Random operation codes, including the unused ones, with random operands and a random fractional select, exercise every operation path, including back-to-back issue.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [2:0] {
      MOP_NONE  = 3'd0,
      MOP_ACC   = 3'd1,
      MOP_LOAD  = 3'd2,
      MOP_CLR   = 3'd3,
      MOP_SHL   = 3'd4,
      MOP_SHR   = 3'd5
   } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OPW     = 16,
   parameter int ACCW    = 40,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic [OPW-1:0]  opa,
   input  logic [OPW-1:0]  opb,
   input  logic            frac,
   output logic [ACCW-1:0] prod_ext
);
   localparam int PW  = 2 * OPW;
   localparam int EXT = ACCW - PW;

   logic signed [PW-1:0] prod;
   logic [ACCW-1:0]      wide;

   always_comb begin
      prod = $signed(opa) * $signed(opb);
      wide = {{EXT{prod[PW-1]}}, prod};
   end

   if (FRAC_EN) begin : g_frac
      always_comb prod_ext = frac ? {wide[ACCW-2:0], 1'b0} : wide;
   end else begin : g_int
      logic unused_frac;
      always_comb unused_frac = frac;
      always_comb prod_ext = wide;
   end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
   import mac_pkg::*;
#(
   parameter int ACCW = 40
) (
   input  mac_op_e         code,
   input  logic [ACCW-1:0] cur,
   input  logic [ACCW-1:0] addend,
   output logic [ACCW-1:0] nxt,
   output logic            ovf_hit
);
   localparam int MSB = ACCW - 1;

   logic [ACCW-1:0] sum;

   always_comb begin
      sum     = cur + addend;
      nxt     = cur;
      ovf_hit = 1'b0;
      case (code)
         MOP_ACC: begin
            nxt     = sum;
            ovf_hit = (cur[MSB] == addend[MSB]) && (sum[MSB] != cur[MSB]);
         end
         MOP_LOAD: nxt = addend;
         MOP_CLR:  nxt = '0;
         MOP_SHL: begin
            nxt     = {cur[MSB-1:0], 1'b0};
            ovf_hit = cur[MSB] ^ cur[MSB-1];
         end
         MOP_SHR:  nxt = {cur[MSB], cur[MSB:1]};
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int OPW     = 16,
   parameter int ACCW    = 40,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [2:0]      op,
   input  logic            frac,
   input  logic [OPW-1:0]  a,
   input  logic [OPW-1:0]  b,
   output logic [ACCW-1:0] acc,
   output logic            ovf,
   output logic            done
);
   localparam int PW = 2 * OPW;

   if (OPW < 2) begin : g_bad_opw
      $error("mac_unit: OPW must be at least 2");
   end
   if (ACCW < PW + 2) begin : g_bad_accw
      $error("mac_unit: ACCW must exceed twice OPW by two or more");
   end

   mac_op_e         code;
   logic [ACCW-1:0] prod_ext;
   logic [ACCW-1:0] acc_nxt;
   logic            ovf_hit;
   logic [ACCW-1:0] acc_q;
   logic            ovf_q;
   logic            done_q;

   always_comb code = mac_op_e'(op);

   mac_mult #(.OPW(OPW), .ACCW(ACCW), .FRAC_EN(FRAC_EN)) u_mult (
      .opa(a), .opb(b), .frac(frac), .prod_ext(prod_ext)
   );

   mac_alu #(.ACCW(ACCW)) u_alu (
      .code(code), .cur(acc_q), .addend(prod_ext),
      .nxt(acc_nxt), .ovf_hit(ovf_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         ovf_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            acc_q <= acc_nxt;
            if (code == MOP_CLR) ovf_q <= 1'b0;
            else                 ovf_q <= ovf_q | ovf_hit;
         end
      end
   end

   assign acc  = acc_q;
   assign ovf  = ovf_q;
   assign done = done_q;

   // R9
   done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(acc) && $stable(ovf)));
   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd3) |=> (acc == '0 && !ovf));
   // R7
   shr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd5) |=> (acc[ACCW-1] == $past(acc[ACCW-1])));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(start && op == 3'd3)) |=> ovf);
   // R6
   shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 3'd4) |=> (acc[0] == 1'b0));
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        frac = 1'b0;
   logic [15:0] a = '0;
   logic [15:0] b = '0;
   logic [39:0] acc;
   logic        ovf;
   logic        done;

   int total = 0;
   int bad   = 0;

   logic [39:0] m_acc = '0;
   logic        m_ovf = 1'b0;

   localparam longint MAXV = (64'sd1 <<< 39) - 1;
   localparam longint MINV = -(64'sd1 <<< 39);

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .frac(frac),
      .a(a), .b(b), .acc(acc), .ovf(ovf), .done(done)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] c, input logic f);
      case (c)
         3'd1: return f ? "R3" : "R2";
         3'd2: return f ? "R3" : "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic model(input logic [2:0] c, input logic [15:0] x, input logic [15:0] y, input logic f);
      longint p   = longint'($signed(x)) * longint'($signed(y));
      longint cur = longint'($signed(m_acc));
      longint s;
      if (f) p = p * 2;
      case (c)
         3'd1: begin
            s = cur + p;
            if (s > MAXV || s < MINV) m_ovf = 1'b1;
            m_acc = s[39:0];
         end
         3'd2: m_acc = p[39:0];
         3'd3: begin m_acc = '0; m_ovf = 1'b0; end
         3'd4: begin
            s = cur * 2;
            if (s > MAXV || s < MINV) m_ovf = 1'b1;
            m_acc = s[39:0];
         end
         3'd5: begin s = cur >>> 1; m_acc = s[39:0]; end
         default: ;
      endcase
   endtask

   task automatic do_op(input logic [2:0] c, input logic [15:0] x, input logic [15:0] y, input logic f);
      start = 1'b1; op = c; a = x; b = y; frac = f;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      model(c, x, y, f);
      check(req_of(c, f), acc, m_acc);
      check("R8", {39'd0, ovf}, {39'd0, m_ovf});
      check("R9", {39'd0, done}, 40'd1);
   endtask

   task automatic idle();
      start = 1'b0;
      op = 3'($urandom_range(7));
      @(posedge clk);
      @(negedge clk);
      check("R9", {39'd0, done}, 40'd0);
      check("R9", acc, m_acc);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd2024));
      @(negedge clk);
      @(negedge clk);
      // R1: state while in reset
      check("R1", acc, 40'd0);
      check("R1", {39'd0, ovf}, 40'd0);
      check("R1", {39'd0, done}, 40'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", acc, 40'd0);
      check("R1", {39'd0, done}, 40'd0);

      // R3: fractional full-scale product
      do_op(3'd2, 16'h8000, 16'h8000, 1'b1);
      check("R3", acc, 40'h0080000000);
      // R6: shift left until the sign bit is reached
      for (int i = 0; i < 8; i++) do_op(3'd4, '0, '0, 1'b0);
      check("R6", acc, 40'h8000000000);
      check("R6", {39'd0, ovf}, 40'd1);
      // R7: arithmetic right shift keeps the sign
      do_op(3'd5, '0, '0, 1'b0);
      check("R7", acc, 40'hC000000000);
      // R10: unused codes hold state
      do_op(3'd6, 16'h1234, 16'h5678, 1'b0);
      check("R10", acc, 40'hC000000000);
      do_op(3'd0, 16'h7FFF, 16'h7FFF, 1'b1);
      check("R10", {39'd0, ovf}, 40'd1);
      idle();
      // R5: clear
      do_op(3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R5", acc, 40'd0);
      check("R5", {39'd0, ovf}, 40'd0);
      // R4: load does not touch the flag
      do_op(3'd2, 16'hFFFE, 16'h0003, 1'b0);
      check("R4", acc, 40'hFFFFFFFFFA);
      // R2: integer accumulate
      do_op(3'd1, 16'h0010, 16'h0002, 1'b0);
      check("R2", acc, 40'hFFFFFFFFFA + 40'h20);

      // R8: accumulate overflow after 128 full-scale fractional products onto 2^38
      do_op(3'd3, '0, '0, 1'b0);
      do_op(3'd2, 16'h8000, 16'h8000, 1'b1);
      for (int i = 0; i < 7; i++) do_op(3'd4, '0, '0, 1'b0);
      check("R8", {39'd0, ovf}, 40'd0);
      for (int i = 0; i < 128; i++) do_op(3'd1, 16'h8000, 16'h8000, 1'b1);
      check("R8", acc, 40'h8000000000);
      check("R8", {39'd0, ovf}, 40'd1);
      do_op(3'd1, 16'h0000, 16'h0005, 1'b0);
      check("R8", {39'd0, ovf}, 40'd1);
      do_op(3'd2, 16'h0001, 16'h0001, 1'b0);
      check("R4", {39'd0, ovf}, 40'd1);
      do_op(3'd3, '0, '0, 1'b0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [2:0] c;
         c = 3'($urandom_range(7));
         if ($urandom_range(3) != 0) c = 3'd1;
         if ($urandom_range(15) == 0) c = 3'd3;
         do_op(c, 16'($urandom), 16'($urandom), 1'($urandom));
         if ($urandom_range(7) == 0) idle();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule